// File: doc/BRIEF.md
# Display Output FIFO with Underrun Recovery

This block sits between a DMA engine and a continuous video pixel stream. The DMA engine writes words into a small circular buffer. The display side pulls one word for each pixel read strobe that falls inside an active line. The block asks for more data with a single-cycle refill pulse once the free space reaches a programmable threshold. It then waits until that many words have arrived before it asks again.

Video output cannot pause, so an empty buffer does not stall the stream. When a pixel is needed and the buffer is empty, the read pointer still advances and the stale word at that slot goes out. The write pointer is pulled along with it, so a late DMA burst lands where the next reads will happen. A sticky underrun flag records the event, and it drives the interrupt line when enabled. A sticky overflow flag records writes dropped against a full buffer.

A block-disable input lets software recover a broken frame. It empties the buffer at once and blocks refill requests and writes. While disabled, a programmable default word is driven on every pixel read. Releasing the control takes effect only at the first frame-start strobe seen after the release.

Top module: `disp_fifo_top`

## Requirements
- R1: After reset the fill level is 0, the pixel output is 0, both status flags are clear, the interrupt is low and the block is not disabled.
- R2: Accepted words leave in write order. One word is consumed per cycle in which `line_active` and `pix_rd` are both high while the block is enabled, and it appears on `pix_data` one cycle later.
- R3: A pixel read while the fill level is 0 is an underrun. The word currently stored at the read slot is driven out, the read pointer advances, the level stays 0, and the next accepted write lands in the slot that the next read will use.
- R4: When `line_active` is low, `pix_rd` is ignored: no word is consumed, no underrun occurs and `pix_data` holds its value.
- R5: The underrun flag is sticky and clears on an `und_clr` pulse, but an underrun in the same cycle keeps it set. `irq` is high exactly when the flag is set and `und_ie` is high.
- R6: A write while the level equals DEPTH is dropped. It sets the sticky overflow flag, which an `ovf_clr` pulse clears (a new drop in the same cycle keeps it set). The level never exceeds DEPTH.
- R7: `refill_req` is a one-cycle pulse issued when no request is outstanding, `thresh` is nonzero and DEPTH minus the level is at least `thresh`. The request stays outstanding until `thresh` words have been accepted after the pulse.
- R8: One cycle after `blk_dis` is sampled high, the buffer is empty and any outstanding request is dropped. While disabled, writes are ignored, no refill pulse is issued, no underrun is flagged, and each pixel read outputs `default_data`.
- R9: After `blk_dis` goes low, the block stays disabled until the first cycle with `frame_start` high and `blk_dis` low. Normal operation resumes from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | DMA write strobe |
| wr_data | input | DATA_W | DMA write word |
| frame_start | input | 1 | Frame boundary strobe |
| line_active | input | 1 | High during the active part of a line |
| pix_rd | input | 1 | Pixel read strobe |
| thresh | input | $clog2(DEPTH)+1 | Refill threshold in words |
| default_data | input | DATA_W | Word output while disabled |
| blk_dis | input | 1 | Block-disable control |
| und_ie | input | 1 | Underrun interrupt enable |
| und_clr | input | 1 | Underrun flag clear pulse |
| ovf_clr | input | 1 | Overflow flag clear pulse |
| pix_data | output | DATA_W | Pixel word out |
| refill_req | output | 1 | Refill request pulse |
| und_sts | output | 1 | Sticky underrun flag |
| ovf_sts | output | 1 | Sticky overflow flag |
| irq | output | 1 | Underrun interrupt |
| fill_level | output | $clog2(DEPTH)+1 | Words held |

## Verification
The bench builds the block with DEPTH = 8 and DATA_W = 16. With these values a handful of writes fills the buffer, so overflow and several pointer wrap-arounds happen within a few dozen cycles. Underrun replays can revisit slots written many laps earlier. Thresholds sweep the full range from 0 to DEPTH, including the value that requests only from an empty buffer and the value 0 that never requests. The random phase has enough cycles for disable, release and frame strobes to line up in every order.

// File: rtl/disp_fifo_pkg.sv
package disp_fifo_pkg;

    // Source of the next pixel output word
    typedef enum logic [1:0] {
        SRC_HOLD    = 2'd0,
        SRC_FIFO    = 2'd1,
        SRC_DEFAULT = 2'd2
    } pix_src_e;

endpackage

// File: rtl/disp_fifo_store.sv
module disp_fifo_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_en,
    input  logic                       flush,
    output logic [DATA_W-1:0]          rd_data,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       underrun,
    output logic                       drop,
    output logic                       wr_acc
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] rp;
        logic [AW-1:0] wp;
        logic [CW-1:0] level;
    } store_t;

    store_t s_d, s_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic empty, full;

    always_comb begin
        empty    = (s_q.level == '0);
        full     = (s_q.level == DEPTH_C);
        wr_acc   = wr_en && !full;
        drop     = wr_en && full;
        underrun = rd_en && empty;
        s_d      = s_q;
        if (underrun) begin
            // keep streaming: skip the slot and drag the write side along
            s_d.rp    = s_q.rp + 1'b1;
            s_d.wp    = s_q.rp + 1'b1;
            s_d.level = '0;
        end else begin
            if (wr_acc) s_d.wp = s_q.wp + 1'b1;
            if (rd_en)  s_d.rp = s_q.rp + 1'b1;
            s_d.level = s_q.level + CW'(wr_acc) - CW'(rd_en);
        end
        if (flush) s_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_acc) begin
            mem_q[s_q.wp] <= wr_data;
        end
    end

    assign rd_data = mem_q[s_q.rp];
    assign level   = s_q.level;

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.level <= DEPTH_C); // R6
    AST_UND_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        underrun && !flush |=> s_q.rp == $past(s_q.rp) + 1'b1); // R3
    AST_UND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun && !flush |=> s_q.level == '0); // R3
    AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        drop && !rd_en && !flush |=> s_q.level == DEPTH_C); // R6

endmodule

// File: rtl/disp_fifo_refill.sv
module disp_fifo_refill #(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   gated,
    input  logic                   blk_dis,
    input  logic                   wr_acc,
    input  logic [$clog2(DEPTH):0] level,
    input  logic [$clog2(DEPTH):0] thresh,
    output logic                   req
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    typedef struct packed {
        logic          outst;
        logic [CW-1:0] cnt;
        logic          req;
    } refill_t;

    refill_t r_d, r_q;
    logic [CW-1:0] free_space;
    logic [CW-1:0] cnt_next;

    always_comb begin
        free_space = DEPTH_C - level;
        cnt_next   = r_q.cnt + CW'(wr_acc);
        r_d        = r_q;
        r_d.req    = 1'b0;
        if (r_q.outst) begin
            if (cnt_next >= thresh) begin
                r_d.outst = 1'b0;
                r_d.cnt   = '0;
            end else begin
                r_d.cnt = cnt_next;
            end
        end else if ((thresh != '0) && (free_space >= thresh)) begin
            r_d.outst = 1'b1;
            r_d.cnt   = '0;
            r_d.req   = 1'b1;
        end
        if (gated || blk_dis) r_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req = r_q.req;

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.req |=> !r_q.req); // R7
    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        gated |=> !r_q.req); // R8
    AST_REQ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.req |-> $past(free_space >= thresh && thresh != '0)); // R7

endmodule

// File: rtl/disp_fifo_ctrl.sv
module disp_fifo_ctrl
    import disp_fifo_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_dis,
    input  logic              frame_start,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic [DATA_W-1:0] default_data,
    input  logic              underrun,
    input  logic              drop,
    input  logic              und_clr,
    input  logic              ovf_clr,
    input  logic              und_ie,
    output logic              gated,
    output logic [DATA_W-1:0] pix_data,
    output logic              und_sts,
    output logic              ovf_sts,
    output logic              irq
);
    typedef struct packed {
        logic              gated;
        logic              und;
        logic              ovf;
        logic [DATA_W-1:0] pix;
    } ctrl_t;

    ctrl_t c_d, c_q;
    pix_src_e src;

    always_comb begin
        if (!rd_req)      src = SRC_HOLD;
        else if (c_q.gated) src = SRC_DEFAULT;
        else              src = SRC_FIFO;

        c_d = c_q;
        unique case (src)
            SRC_FIFO:    c_d.pix = fifo_data;
            SRC_DEFAULT: c_d.pix = default_data;
            default:     c_d.pix = c_q.pix;
        endcase

        if (blk_dis)          c_d.gated = 1'b1;
        else if (frame_start) c_d.gated = 1'b0;

        c_d.und = (c_q.und && !und_clr) || underrun;
        c_d.ovf = (c_q.ovf && !ovf_clr) || drop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign gated    = c_q.gated;
    assign pix_data = c_q.pix;
    assign und_sts  = c_q.und;
    assign ovf_sts  = c_q.ovf;
    assign irq      = c_q.und && und_ie;

    AST_UND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.und && !und_clr |=> c_q.und); // R5
    AST_UND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> c_q.und); // R5
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> c_q.ovf); // R6
    AST_RELEASE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.gated && !frame_start |=> c_q.gated); // R9
    AST_BLANK_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.gated && rd_req |=> c_q.pix == $past(default_data)); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(c_q.pix)); // R4

endmodule

// File: rtl/disp_fifo_top.sv
module disp_fifo_top #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_valid,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   frame_start,
    input  logic                   line_active,
    input  logic                   pix_rd,
    input  logic [$clog2(DEPTH):0] thresh,
    input  logic [DATA_W-1:0]      default_data,
    input  logic                   blk_dis,
    input  logic                   und_ie,
    input  logic                   und_clr,
    input  logic                   ovf_clr,
    output logic [DATA_W-1:0]      pix_data,
    output logic                   refill_req,
    output logic                   und_sts,
    output logic                   ovf_sts,
    output logic                   irq,
    output logic [$clog2(DEPTH):0] fill_level
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic              gated;
    logic              rd_req;
    logic              underrun;
    logic              drop;
    logic              wr_acc;
    logic [DATA_W-1:0] fifo_data;
    logic [CW-1:0]     level;

    assign rd_req = line_active && pix_rd;

    disp_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_valid && !gated),
        .wr_data  (wr_data),
        .rd_en    (rd_req && !gated),
        .flush    (blk_dis),
        .rd_data  (fifo_data),
        .level    (level),
        .underrun (underrun),
        .drop     (drop),
        .wr_acc   (wr_acc)
    );

    disp_fifo_refill #(.DEPTH(DEPTH)) refill_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .gated   (gated),
        .blk_dis (blk_dis),
        .wr_acc  (wr_acc),
        .level   (level),
        .thresh  (thresh),
        .req     (refill_req)
    );

    disp_fifo_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .blk_dis      (blk_dis),
        .frame_start  (frame_start),
        .rd_req       (rd_req),
        .fifo_data    (fifo_data),
        .default_data (default_data),
        .underrun     (underrun),
        .drop         (drop),
        .und_clr      (und_clr),
        .ovf_clr      (ovf_clr),
        .und_ie       (und_ie),
        .gated        (gated),
        .pix_data     (pix_data),
        .und_sts      (und_sts),
        .ovf_sts      (ovf_sts),
        .irq          (irq)
    );

    assign fill_level = level;

endmodule

// File: tb/disp_fifo_tb.sv
module disp_fifo_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 8;
    localparam int CW     = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic frame_start = 1'b0;
    logic line_active = 1'b0;
    logic pix_rd = 1'b0;
    logic [CW-1:0] thresh = CW'(4);
    logic [DATA_W-1:0] default_data = 16'hDEAD;
    logic blk_dis = 1'b0;
    logic und_ie = 1'b0;
    logic und_clr = 1'b0;
    logic ovf_clr = 1'b0;
    logic [DATA_W-1:0] pix_data;
    logic refill_req, und_sts, ovf_sts, irq;
    logic [CW-1:0] fill_level;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_fifo_top #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .frame_start(frame_start), .line_active(line_active), .pix_rd(pix_rd),
        .thresh(thresh), .default_data(default_data), .blk_dis(blk_dis),
        .und_ie(und_ie), .und_clr(und_clr), .ovf_clr(ovf_clr),
        .pix_data(pix_data), .refill_req(refill_req), .und_sts(und_sts),
        .ovf_sts(ovf_sts), .irq(irq), .fill_level(fill_level)
    );

    // ---------------- behavioural reference ----------------
    int  m_level, m_rd, m_wr, m_pix, m_wcnt;
    bit  m_gated, m_req, m_outst, m_und, m_ovf;
    int  m_slot [DEPTH];

    task automatic model_reset();
        m_level = 0; m_rd = 0; m_wr = 0; m_pix = 0; m_wcnt = 0;
        m_gated = 0; m_req = 0; m_outst = 0; m_und = 0; m_ovf = 0;
        for (int i = 0; i < DEPTH; i++) m_slot[i] = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit rd, acc, dropw, uevt, nreq;
            int old_level;
            rd = line_active && pix_rd;
            acc = 0; dropw = 0; uevt = 0; nreq = 0;
            old_level = m_level;
            if (m_gated) begin
                if (rd) m_pix = default_data;
                m_outst = 0; m_wcnt = 0;
            end else begin
                acc   = wr_valid && (m_level < DEPTH);
                dropw = wr_valid && (m_level == DEPTH);
                uevt  = rd && (m_level == 0);
                if (rd) m_pix = m_slot[m_rd];
                if (acc) m_slot[m_wr] = wr_data;
                if (uevt) begin
                    m_rd = (m_rd + 1) % DEPTH; m_wr = m_rd; m_level = 0;
                end else begin
                    if (acc) begin m_wr = (m_wr + 1) % DEPTH; m_level++; end
                    if (rd)  begin m_rd = (m_rd + 1) % DEPTH; m_level--; end
                end
                if (m_outst) begin
                    if (m_wcnt + acc >= thresh) begin m_outst = 0; m_wcnt = 0; end
                    else m_wcnt = m_wcnt + acc;
                end else if (thresh != 0 && (DEPTH - old_level) >= thresh) begin
                    m_outst = 1; m_wcnt = 0; nreq = 1;
                end
            end
            m_req = nreq && !blk_dis;
            m_und = (m_und && !und_clr) || uevt;
            m_ovf = (m_ovf && !ovf_clr) || dropw;
            if (blk_dis) begin
                m_level = 0; m_rd = 0; m_wr = 0; m_outst = 0; m_wcnt = 0;
            end
            if (blk_dis) m_gated = 1;
            else if (frame_start) m_gated = 0;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // compare on every clock, before inputs move
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 R3 R4 R8 pix_data", int'(pix_data), m_pix);
            check("R6 R8 fill_level", int'(fill_level), m_level);
            check("R7 R9 refill_req", int'(refill_req), int'(m_req));
            check("R3 R5 und_sts", int'(und_sts), int'(m_und));
            check("R6 ovf_sts", int'(ovf_sts), int'(m_ovf));
            check("R5 irq", int'(irq), int'(m_und && und_ie));
        end
    end

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic clear_strobes();
        wr_valid = 0; pix_rd = 0; und_clr = 0; ovf_clr = 0; frame_start = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        cyc(3);
        // R1: reset state seen at the ports
        check("R1 fill_level", int'(fill_level), 0);
        check("R1 pix_data", int'(pix_data), 0);
        check("R1 flags", int'({und_sts, ovf_sts, irq, refill_req}), 0);
        rst_n = 1;
        cyc(2);

        // R2 R6: fill past full, then clear overflow
        for (int i = 0; i < DEPTH + 2; i++) begin
            wr_valid = 1; wr_data = 16'h1000 + 16'(i); cyc();
        end
        clear_strobes();
        check("R6 full level", int'(fill_level), DEPTH);
        check("R6 overflow set", int'(ovf_sts), 1);
        ovf_clr = 1; cyc(); clear_strobes();

        // R4: reads outside the active line do nothing
        pix_rd = 1; line_active = 0; cyc(3);
        check("R4 level unchanged", int'(fill_level), DEPTH);

        // R2 R3: drain past empty into underrun
        und_ie = 1; line_active = 1;
        for (int i = 0; i < DEPTH + 3; i++) cyc();
        pix_rd = 0; cyc();
        check("R3 underrun flag", int'(und_sts), 1);
        check("R5 irq asserted", int'(irq), 1);

        // R3: late write lands where the next read goes
        wr_valid = 1; wr_data = 16'hBEEF; cyc(); clear_strobes();
        pix_rd = 1; cyc(); pix_rd = 0; cyc();
        check("R3 late word delivered", int'(pix_data), 16'hBEEF);

        // R5: clear coinciding with a fresh underrun keeps the flag
        pix_rd = 1; und_clr = 1; cyc(); clear_strobes(); cyc();
        check("R5 clear loses to event", int'(und_sts), 1);
        und_clr = 1; cyc(); clear_strobes(); cyc();
        check("R5 cleared", int'(und_sts), 0);

        // R7: threshold sweep with concurrent traffic
        for (int t = 0; t <= DEPTH; t++) begin
            thresh = CW'(t);
            for (int k = 0; k < 20; k++) begin
                wr_valid = (k % 3) != 0; wr_data = 16'(t * 64 + k);
                pix_rd = (k % 2) == 0; cyc();
            end
        end
        clear_strobes();

        // R8 R9: disable, release mid-frame, resume only at frame start
        thresh = CW'(2);
        wr_valid = 1; wr_data = 16'h7777; cyc(3); clear_strobes();
        blk_dis = 1; cyc();
        check("R8 flushed", int'(fill_level), 0);
        wr_valid = 1; pix_rd = 1; cyc(3); clear_strobes();
        check("R8 default output", int'(pix_data), 16'hDEAD);
        check("R8 writes ignored", int'(fill_level), 0);
        frame_start = 1; cyc(); clear_strobes();   // still disabled
        blk_dis = 0; cyc(4);
        check("R9 no request before frame", int'(refill_req), 0);
        frame_start = 1; cyc(); clear_strobes(); cyc();
        check("R9 request after frame", int'(refill_req), 1);

        // random mix of everything
        for (int i = 0; i < 6000; i++) begin
            wr_valid    = ($urandom % 100) < 55;
            wr_data     = 16'($urandom);
            pix_rd      = ($urandom % 100) < 50;
            line_active = (i % 40) < 30;
            frame_start = (i % 400) == 0;
            und_clr     = ($urandom % 50) == 0;
            ovf_clr     = ($urandom % 50) == 0;
            und_ie      = ($urandom % 8) != 0;
            if ((i % 300) == 100) blk_dis = 1;
            if ((i % 300) == 120) blk_dis = 0;
            if ((i % 500) == 0) thresh = CW'($urandom % (DEPTH + 1));
            if ((i % 700) == 0) default_data = 16'($urandom);
            cyc();
        end
        clear_strobes();
        blk_dis = 0;
        cyc(3);
        finish_run();
    end

endmodule